// File: doc/BRIEF.md
# Byte-Granular Table Access Controller

This block sits between an 8-bit data path and a program memory that is 16 bits wide. A byte pointer and an 8-bit latch form its register interface. A read request copies one addressed byte of memory into the latch. A write request copies the latch into one slot of a small holding buffer. A commit request programs the whole holding buffer into memory in one operation. An erase request restores a larger aligned block to the erased value. While a commit or an erase runs, an internal timer keeps the block busy and the instruction-fetch stall output is raised.

Bit 0 of the pointer picks the byte within a 16-bit word, and the upper bits pick the word. Tables therefore need no alignment: they can begin and end at any byte address. Programming can only clear bits, and erase sets bits. A block that has been erased is rebuilt by several commits, one for each holding-buffer-sized piece.

The controller is a four-state machine:
- `ST_IDLE` accepts requests.
- `ST_RD_WAIT` waits one cycle for the registered memory read.
- `ST_PROG` and `ST_ERASE` are the timed busy phases.

The transitions are:
- `ST_IDLE -> ST_RD_WAIT` on a read request.
- `ST_RD_WAIT -> ST_IDLE` always.
- `ST_IDLE -> ST_PROG` on a commit.
- `ST_IDLE -> ST_ERASE` on an erase.
- `ST_PROG/ST_ERASE -> ST_IDLE` when the timer reaches its last count.

A write request is handled in `ST_IDLE` and does not leave that state.

Top module: `byte_table_bridge`

## Requirements
- R1: A read request accepted in `ST_IDLE` loads the latch with one memory byte. The latch changes on the second clock edge after the request is sampled. Pointer bit 0 = 0 selects bits 7:0 of word `ptr>>1`, and bit 0 = 1 selects bits 15:8. Requests sampled in `ST_RD_WAIT` are ignored.
- R2: A write request accepted in `ST_IDLE` copies the latch into holding slot `ptr mod HOLD_BYTES` (slot k holds byte k of the block). Memory is not changed.
- R3: A commit programs the block of HOLD_BYTES bytes that starts at `ptr` with its low log2(HOLD_BYTES) bits cleared. Each byte at base+k becomes its old value AND slot k. All slots then return to 0xFF.
- R4: An erase sets every byte of the 64-byte aligned block that contains `ptr` to 0xFF. All other bytes are unchanged.
- R5: After a commit or an erase is accepted, `fetch_stall` is high for exactly PROG_CYCLES consecutive cycles, starting at the next edge. It goes low on the edge after that. While it is high, read, write, commit and erase requests are ignored.
- R6: A bulk-erase request changes neither memory, nor the holding slots, nor `fetch_stall`. `bulk_rej` is high in the cycle after every cycle in which `bulk_req` is high.
- R7: In `ST_IDLE`, requests in the same cycle are ranked erase, then commit, then read, then write. Only the highest one is performed, and the others are dropped.
- R8: A request in the same cycle as a pointer or latch load uses the values from before the load. A read result arriving in `ST_RD_WAIT` takes precedence over a latch load in that cycle.
- R9: After reset, the pointer and the latch are 0, all slots are 0xFF, all memory bytes are 0xFF, `fetch_stall` and `bulk_rej` are 0, and the state is `ST_IDLE`.
- R10: Pointer and latch loads take effect at the next edge in every state, including the busy states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Load the pointer from `ptr_in` |
| ptr_in | input | PTR_W | New byte pointer value |
| lat_wr | input | 1 | Load the latch from `lat_in` |
| lat_in | input | 8 | New latch value |
| rd_req | input | 1 | Table read request |
| wr_req | input | 1 | Table write request (latch to holding slot) |
| commit_req | input | 1 | Program the holding block into memory |
| erase_req | input | 1 | Erase the aligned erase block |
| bulk_req | input | 1 | Bulk erase request (always rejected) |
| ptr_q | output | PTR_W | Current byte pointer |
| lat_q | output | 8 | Current latch value |
| fetch_stall | output | 1 | Instruction fetch must wait |
| bulk_rej | output | 1 | Rejection pulse for a bulk request |

## Verification
Several requests often fall in the same cycle: a table read or write together with a pointer or latch load, and a commit or erase together with a lower-ranked read or write. The stimulus sets each request line independently every cycle, so these coincidences occur often. A behavioural byte-array model decides which operation wins and which pointer and latch values it used. Each outcome is judged through the latch, after the fact, by later reads of the bytes and slots involved. A final read sweep over the whole memory makes sure that no dropped request left a trace.

// File: rtl/tbb_pkg.sv
package tbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_PROG    = 2'd2,
        ST_ERASE   = 2'd3
    } tbb_state_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_COMMIT = 3'd3,
        OP_ERASE  = 3'd4
    } tbb_op_e;

    localparam logic [7:0]  BYTE_ERASED = 8'hFF;
    localparam logic [15:0] WORD_ERASED = 16'hFFFF;
endpackage

// File: rtl/tbb_timer.sv
module tbb_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(CYCLES - 1);
        end else if (run) begin
            if (cnt == '0) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign busy = run;
    assign last = run && (cnt == '0);

    // R5: the count only ends when it reaches zero
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> run);
    // R5: a new operation is never started on top of a running one
    a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);
endmodule

// File: rtl/tbb_hold.sv
module tbb_hold #(
    parameter int BYTES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(BYTES)-1:0] slot,
    input  logic [7:0]               din,
    input  logic                     clr,
    output logic [BYTES*8-1:0]       block
);
    import tbb_pkg::*;

    logic [7:0] regs [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) regs[i] <= BYTE_ERASED;
        end else if (clr) begin
            for (int i = 0; i < BYTES; i++) regs[i] <= BYTE_ERASED;
        end else if (wr_en) begin
            regs[slot] <= din;
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_pack
        assign block[g*8 +: 8] = regs[g];
    end

    // R2: a written slot holds the latch byte presented with the write
    a_r2_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> regs[$past(slot)] == $past(din));
    // R3: write and clear never coincide
    a_r3_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr));
endmodule

// File: rtl/tbb_mem.sv
module tbb_mem #(
    parameter int WORDS       = 256,
    parameter int HOLD_WORDS  = 8,
    parameter int ERASE_WORDS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [15:0]              rd_data,
    input  logic                     prog_en,
    input  logic [$clog2(WORDS)-1:0] prog_base,
    input  logic [HOLD_WORDS*16-1:0] prog_data,
    input  logic                     erase_en,
    input  logic [$clog2(WORDS)-1:0] erase_base
);
    import tbb_pkg::*;

    logic [15:0] mem [WORDS];
    int          prog_blk;
    int          erase_blk;

    assign prog_blk  = int'(prog_base) / HOLD_WORDS;
    assign erase_blk = int'(erase_base) / ERASE_WORDS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= WORD_ERASED;
        end else begin
            if (rd_en) rd_data <= mem[rd_addr];
            for (int i = 0; i < WORDS; i++) begin
                if (erase_en && (i / ERASE_WORDS) == erase_blk) begin
                    mem[i] <= WORD_ERASED;
                end else if (prog_en && (i / HOLD_WORDS) == prog_blk) begin
                    mem[i] <= mem[i] & prog_data[(i % HOLD_WORDS)*16 +: 16];
                end
            end
        end
    end

    // R5: only one array operation per cycle
    a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_en, prog_en, erase_en}) <= 1);
endmodule

// File: rtl/byte_table_bridge.sv
module byte_table_bridge #(
    parameter int MEM_WORDS   = 256,
    parameter int HOLD_BYTES  = 16,
    parameter int ERASE_BYTES = 64,
    parameter int PROG_CYCLES = 20,
    localparam int PTR_W      = $clog2(MEM_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic             lat_wr,
    input  logic [7:0]       lat_in,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic             commit_req,
    input  logic             erase_req,
    input  logic             bulk_req,
    output logic [PTR_W-1:0] ptr_q,
    output logic [7:0]       lat_q,
    output logic             fetch_stall,
    output logic             bulk_rej
);
    import tbb_pkg::*;

    localparam int WADDR_W     = PTR_W - 1;
    localparam int HOLD_W      = $clog2(HOLD_BYTES);
    localparam int HOLD_WORDS  = HOLD_BYTES / 2;
    localparam int ERASE_WORDS = ERASE_BYTES / 2;

    tbb_state_e state, state_nxt;
    tbb_op_e    op;

    logic                     rd_hi;
    logic                     mem_rd_en, prog_en, erase_en, hold_wr, hold_clr, t_start;
    logic                     t_busy, t_last;
    logic [15:0]              rd_data;
    logic [HOLD_BYTES*8-1:0]  hold_block;
    logic [WADDR_W-1:0]       word_addr, prog_base, erase_base;

    assign word_addr  = ptr_q[PTR_W-1:1];
    assign prog_base  = word_addr & ~WADDR_W'(HOLD_WORDS - 1);
    assign erase_base = word_addr & ~WADDR_W'(ERASE_WORDS - 1);

    // request ranking in the accepting state
    always_comb begin
        op = OP_NONE;
        if (state == ST_IDLE) begin
            if (erase_req)       op = OP_ERASE;
            else if (commit_req) op = OP_COMMIT;
            else if (rd_req)     op = OP_READ;
            else if (wr_req)     op = OP_WRITE;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (op == OP_ERASE)       state_nxt = ST_ERASE;
                else if (op == OP_COMMIT) state_nxt = ST_PROG;
                else if (op == OP_READ)   state_nxt = ST_RD_WAIT;
            end
            ST_RD_WAIT: state_nxt = ST_IDLE;
            ST_PROG:    if (t_last) state_nxt = ST_IDLE;
            ST_ERASE:   if (t_last) state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs and strobes
    always_comb begin
        mem_rd_en   = 1'b0;
        prog_en     = 1'b0;
        erase_en    = 1'b0;
        hold_wr     = 1'b0;
        hold_clr    = 1'b0;
        t_start     = 1'b0;
        fetch_stall = 1'b0;
        unique case (state)
            ST_IDLE: begin
                unique case (op)
                    OP_ERASE:  begin erase_en = 1'b1; t_start = 1'b1; end
                    OP_COMMIT: begin prog_en = 1'b1; hold_clr = 1'b1; t_start = 1'b1; end
                    OP_READ:   mem_rd_en = 1'b1;
                    OP_WRITE:  hold_wr = 1'b1;
                    OP_NONE:   ;
                    default:   ;
                endcase
            end
            ST_RD_WAIT: ;
            ST_PROG:    fetch_stall = 1'b1;
            ST_ERASE:   fetch_stall = 1'b1;
        endcase
    end

    // pointer, latch, byte select, bulk rejection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            lat_q    <= '0;
            rd_hi    <= 1'b0;
            bulk_rej <= 1'b0;
        end else begin
            bulk_rej <= bulk_req;
            if (ptr_wr) ptr_q <= ptr_in;
            if (mem_rd_en) rd_hi <= ptr_q[0];
            if (state == ST_RD_WAIT)
                lat_q <= rd_hi ? rd_data[15:8] : rd_data[7:0];
            else if (lat_wr)
                lat_q <= lat_in;
        end
    end

    tbb_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .busy  (t_busy),
        .last  (t_last)
    );

    tbb_hold #(.BYTES(HOLD_BYTES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (hold_wr),
        .slot  (ptr_q[HOLD_W-1:0]),
        .din   (lat_q),
        .clr   (hold_clr),
        .block (hold_block)
    );

    tbb_mem #(
        .WORDS       (MEM_WORDS),
        .HOLD_WORDS  (HOLD_WORDS),
        .ERASE_WORDS (ERASE_WORDS)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (mem_rd_en),
        .rd_addr    (word_addr),
        .rd_data    (rd_data),
        .prog_en    (prog_en),
        .prog_base  (prog_base),
        .prog_data  (hold_block),
        .erase_en   (erase_en),
        .erase_base (erase_base)
    );

    // R5: no access to the array or the holding slots while stalled
    a_r5_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> !(mem_rd_en || prog_en || erase_en || hold_wr));
    // R5: the stall output tracks the programming timer
    a_r5_stall_timer: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall == t_busy);
    // R4: an accepted erase stalls fetch from the next edge
    a_r4_erase_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> fetch_stall);
    // R1: the read wait lasts one cycle
    a_r1_rd_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_WAIT) |=> (state == ST_IDLE));
    // R6: a bulk request pulses the rejection flag
    a_r6_bulk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_req |=> bulk_rej);
    // R6: a lone bulk request never starts a busy phase
    a_r6_bulk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && bulk_req && !erase_req && !commit_req) |=> !fetch_stall);
endmodule

// File: tb/byte_table_bridge_bench.sv
module byte_table_bridge_bench;
    localparam int MEM_WORDS   = 256;
    localparam int HOLD_BYTES  = 16;
    localparam int ERASE_BYTES = 64;
    localparam int PROG_CYCLES = 20;
    localparam int PTR_W       = $clog2(MEM_WORDS) + 1;
    localparam int NBYTES      = MEM_WORDS * 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ptr_wr, lat_wr, rd_req, wr_req, commit_req, erase_req, bulk_req;
    logic [PTR_W-1:0] ptr_in;
    logic [7:0]       lat_in;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       lat_q;
    logic             fetch_stall, bulk_rej;

    always #4 clk = ~clk;

    byte_table_bridge #(
        .MEM_WORDS   (MEM_WORDS),
        .HOLD_BYTES  (HOLD_BYTES),
        .ERASE_BYTES (ERASE_BYTES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_byte_table_bridge (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr(ptr_wr), .ptr_in(ptr_in), .lat_wr(lat_wr), .lat_in(lat_in),
        .rd_req(rd_req), .wr_req(wr_req), .commit_req(commit_req),
        .erase_req(erase_req), .bulk_req(bulk_req),
        .ptr_q(ptr_q), .lat_q(lat_q), .fetch_stall(fetch_stall), .bulk_rej(bulk_rej)
    );

    // behavioural reference: 0 idle, 1 read wait, 2 busy
    byte m_mem [NBYTES];
    byte m_hold [HOLD_BYTES];
    int  m_ptr, m_lat, m_state, m_cnt, m_rd_addr, m_bulk;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) m_mem[i] = 8'hFF;
            for (int i = 0; i < HOLD_BYTES; i++) m_hold[i] = 8'hFF;
            m_ptr = 0; m_lat = 0; m_state = 0; m_cnt = 0; m_rd_addr = 0; m_bulk = 0;
        end else begin
            int new_lat;
            int base;
            new_lat = lat_wr ? int'(lat_in) : m_lat;
            m_bulk = int'(bulk_req);
            case (m_state)
                0: begin
                    if (erase_req) begin
                        base = m_ptr - (m_ptr % ERASE_BYTES);
                        for (int k = 0; k < ERASE_BYTES; k++) m_mem[base+k] = 8'hFF;
                        m_state = 2; m_cnt = PROG_CYCLES;
                    end else if (commit_req) begin
                        base = m_ptr - (m_ptr % HOLD_BYTES);
                        for (int k = 0; k < HOLD_BYTES; k++) begin
                            m_mem[base+k] = m_mem[base+k] & m_hold[k];
                            m_hold[k] = 8'hFF;
                        end
                        m_state = 2; m_cnt = PROG_CYCLES;
                    end else if (rd_req) begin
                        m_rd_addr = m_ptr; m_state = 1;
                    end else if (wr_req) begin
                        m_hold[m_ptr % HOLD_BYTES] = byte'(m_lat);
                    end
                end
                1: begin
                    new_lat = int'(m_mem[m_rd_addr]) & 255;
                    m_state = 0;
                end
                default: begin
                    m_cnt--;
                    if (m_cnt == 0) m_state = 0;
                end
            endcase
            m_lat = new_lat;
            if (ptr_wr) m_ptr = int'(ptr_in);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2/R3/R4/R7/R8 latch", int'(lat_q), m_lat);
        chk("R10 pointer", int'(ptr_q), m_ptr);
        chk("R5 fetch_stall", int'(fetch_stall), (m_state == 2) ? 1 : 0);
        chk("R6 bulk_rej", int'(bulk_rej), m_bulk);
    endtask

    task automatic idle_inputs();
        ptr_wr = 0; lat_wr = 0; rd_req = 0; wr_req = 0;
        commit_req = 0; erase_req = 0; bulk_req = 0;
        ptr_in = '0; lat_in = '0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED1234));
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset latch", int'(lat_q), 0);
        chk("R9 reset pointer", int'(ptr_q), 0);
        chk("R9 reset stall", int'(fetch_stall), 0);
        chk("R9 reset bulk_rej", int'(bulk_rej), 0);
        rst_n = 1'b1;

        // directed: odd/even byte read of erased memory, write and commit, R1 R2 R3
        step(); ptr_wr = 1; ptr_in = PTR_W'(37); lat_wr = 1; lat_in = 8'h5A;
        step(); idle_inputs(); wr_req = 1;
        step(); idle_inputs(); commit_req = 1; rd_req = 1; wr_req = 1;   // R7 ranking
        step(); idle_inputs(); rd_req = 1; wr_req = 1; bulk_req = 1;     // R5 ignored while busy
        repeat (PROG_CYCLES + 2) begin step(); idle_inputs(); end
        rd_req = 1; ptr_wr = 1; ptr_in = PTR_W'(36);                     // R8 old pointer used
        step(); idle_inputs(); lat_wr = 1; lat_in = 8'h11;               // R8 read beats latch load
        step(); idle_inputs(); rd_req = 1;
        step(); idle_inputs();
        step();

        // mixed traffic
        for (int c = 0; c < 4000; c++) begin
            idle_inputs();
            ptr_wr     = ($urandom % 100) < 30;
            ptr_in     = PTR_W'($urandom);
            lat_wr     = ($urandom % 100) < 30;
            lat_in     = 8'($urandom);
            rd_req     = ($urandom % 100) < 30;
            wr_req     = ($urandom % 100) < 35;
            commit_req = ($urandom % 100) < 5;
            erase_req  = ($urandom % 100) < 2;
            bulk_req   = ($urandom % 100) < 5;
            step();
        end

        // full read-back sweep, R3 R4 R6 persistence
        idle_inputs();
        repeat (PROG_CYCLES + 4) step();
        for (int a = 0; a < NBYTES; a++) begin
            idle_inputs(); ptr_wr = 1; ptr_in = PTR_W'(a);
            step();
            idle_inputs(); rd_req = 1;
            step();
            idle_inputs();
            step();
            step();
        end
        finish_run();
    end
endmodule